// File: doc/BRIEF.md
# Dual Serial Word Queue with Threshold Interrupts

This block holds two independent word queues that sit between a host bus and a serial shift engine. The transmit queue is written by the host and drained by the shift engine. The receive queue is filled by the shift engine and drained by the host. Each queue is eight entries deep. Each stored word is cut to the configured word length, which can be from 2 to 16 bits.

Each queue shows its current fill level. Each raises an interrupt when that level crosses its own programmable threshold. The receive interrupt fires when the queue has filled up to the threshold. The transmit interrupt fires when the queue has drained down to the threshold. A push into a full queue and a pop from an empty queue both set sticky error flags, which stay set until they are cleared. Each queue has its own enable, flush and error-clear controls.

A pop takes effect at a clock edge. The popped word appears on the read-data output after that edge and stays there until the next successful pop.

Top module: `sfifo_pair`

## Requirements
- R1: After reset, both levels are 0, both read-data outputs are 0, all error flags are 0 and both interrupts are low.
- R2: Each queue returns words in the order they were written. Its level counts accepted pushes minus accepted pops and never goes above 8.
- R3: Pushed data is masked to its low L bits, where L comes from `wlen_i`. Values below 2 are treated as 2 and values above 16 are treated as 16.
- R4: While the queue is enabled, the receive interrupt is high exactly when the receive level is at or above `rx_trig_i`.
- R5: While the queue is enabled, the transmit interrupt is high exactly when the transmit level is at or below `tx_trig_i`.
- R6: A push into a full queue, with no pop in the same cycle, discards the word and sets that queue's overrun flag. The flag stays set.
- R7: A pop from an empty queue sets that queue's underflow flag, which stays set. The read-data output keeps the last word that was validly popped.
- R8: A high on a queue's error-clear input clears both of its error flags at the next edge, unless a new error occurs in that same cycle.
- R9: A flush empties only the selected queue, at the next edge. Pushes and pops in that cycle are ignored, and the other queue is unaffected.
- R10: While a queue's enable is low, its pushes and pops are ignored (level and data unchanged) and its interrupt is low.
- R11: A push and a pop in the same cycle on a full queue both take effect. The level stays 8 and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wlen_i | input | 5 | Configured word length in bits |
| tx_en_i | input | 1 | Transmit queue enable |
| tx_flush_i | input | 1 | Empty the transmit queue |
| tx_trig_i | input | 4 | Transmit interrupt threshold |
| tx_err_clr_i | input | 1 | Clear transmit error flags |
| tx_wr_i | input | 1 | Host write strobe |
| tx_wdata_i | input | 16 | Host write data |
| tx_pop_i | input | 1 | Shift engine pop strobe |
| tx_rdata_o | output | 16 | Word handed to the shift engine |
| tx_level_o | output | 4 | Transmit fill level |
| tx_irq_o | output | 1 | Transmit threshold interrupt |
| tx_ovr_o | output | 1 | Transmit overrun flag |
| tx_udf_o | output | 1 | Transmit underflow flag |
| rx_en_i | input | 1 | Receive queue enable |
| rx_flush_i | input | 1 | Empty the receive queue |
| rx_trig_i | input | 4 | Receive interrupt threshold |
| rx_err_clr_i | input | 1 | Clear receive error flags |
| rx_push_i | input | 1 | Shift engine push strobe |
| rx_wdata_i | input | 16 | Received word |
| rx_rd_i | input | 1 | Host read strobe |
| rx_rdata_o | output | 16 | Word returned to the host |
| rx_level_o | output | 4 | Receive fill level |
| rx_irq_o | output | 1 | Receive threshold interrupt |
| rx_ovr_o | output | 1 | Receive overrun flag |
| rx_udf_o | output | 1 | Receive underflow flag |

## Verification
The bench uses the default parameters: a depth of 8 and a width of 16. At depth 8 the full-queue cases are reached in a few cycles: overrun, the push-and-pop exchange on a full queue, and the pointer wrap. At width 16 the bench can check both ends of the length clamp, with the full 16-bit word and with requests below 2 bits forced up to 2. The receive threshold is set to 3 and the transmit threshold to 2, so the bench can see each interrupt switch on both sides of its threshold.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic {IRQ_AT_OR_ABOVE, IRQ_AT_OR_BELOW} irq_mode_e;
endpackage

// File: rtl/sfifo_trig.sv
module sfifo_trig
  import sfifo_pkg::*;
#(
  parameter int unsigned LVL_W = 4,
  parameter irq_mode_e   MODE  = IRQ_AT_OR_ABOVE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trig_i,
  output logic             irq_o
);
  logic hit;

  generate
    if (MODE == IRQ_AT_OR_ABOVE) begin : g_above
      assign hit = (level_i >= trig_i);
    end else begin : g_below
      assign hit = (level_i <= trig_i);
    end
  endgenerate

  assign irq_o = en_i & hit;

  a_r10_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o);
endmodule

// File: rtl/sfifo_core.sv
module sfifo_core
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16,
  parameter irq_mode_e   MODE  = IRQ_AT_OR_ABOVE,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned LEN_W = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             flush_i,
  input  logic             err_clr_i,
  input  logic [LVL_W-1:0] trig_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             irq_o,
  output logic             ovr_o,
  output logic             udf_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [WIDTH-1:0] mask;
  logic [LEN_W-1:0] eff_len;
  logic             full, empty, do_push, do_pop, ovr_set, udf_set;

  // clamp word length into [2, WIDTH]
  always_comb begin
    eff_len = len_i;
    if (len_i < LEN_W'(2))          eff_len = LEN_W'(2);
    else if (len_i > LEN_W'(WIDTH)) eff_len = LEN_W'(WIDTH);
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_mask
    assign mask[b] = (LEN_W'(b) < eff_len);
  end

  assign full    = (level_o == FULL_LVL);
  assign empty   = (level_o == '0);
  assign do_pop  = en_i & pop_i & ~empty & ~flush_i;
  assign do_push = en_i & push_i & (~full | do_pop) & ~flush_i;
  assign ovr_set = en_i & push_i & full & ~do_pop & ~flush_i;
  assign udf_set = en_i & pop_i & empty & ~flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i & mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_o <= '0;
      rdata_o <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_o <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr  <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        rdata_o <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   level_o <= level_o + 1'b1;
        2'b01:   level_o <= level_o - 1'b1;
        default: level_o <= level_o;
      endcase
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      ovr_o <= ovr_set | (ovr_o & ~err_clr_i);
      udf_o <= udf_set | (udf_o & ~err_clr_i);
    end
  end

  sfifo_trig #(.LVL_W(LVL_W), .MODE(MODE)) i_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .level_i (level_o),
    .trig_i  (trig_i),
    .irq_o   (irq_o)
  );

  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= FULL_LVL);
  a_r6_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !err_clr_i |=> ovr_o);
  a_r6_ovr_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && push_i && !pop_i && !flush_i && level_o == FULL_LVL
    |=> ovr_o && level_o == FULL_LVL);
  a_r7_udf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && pop_i && !flush_i && level_o == '0 |=> udf_o && $stable(rdata_o));
  a_r9_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> level_o == '0);
  a_r10_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !flush_i |=> $stable(level_o) && $stable(rdata_o));
endmodule

// File: rtl/sfifo_pair.sv
module sfifo_pair
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned LEN_W = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] wlen_i,
  input  logic             tx_en_i,
  input  logic             tx_flush_i,
  input  logic [LVL_W-1:0] tx_trig_i,
  input  logic             tx_err_clr_i,
  input  logic             tx_wr_i,
  input  logic [WIDTH-1:0] tx_wdata_i,
  input  logic             tx_pop_i,
  output logic [WIDTH-1:0] tx_rdata_o,
  output logic [LVL_W-1:0] tx_level_o,
  output logic             tx_irq_o,
  output logic             tx_ovr_o,
  output logic             tx_udf_o,
  input  logic             rx_en_i,
  input  logic             rx_flush_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             rx_err_clr_i,
  input  logic             rx_push_i,
  input  logic [WIDTH-1:0] rx_wdata_i,
  input  logic             rx_rd_i,
  output logic [WIDTH-1:0] rx_rdata_o,
  output logic [LVL_W-1:0] rx_level_o,
  output logic             rx_irq_o,
  output logic             rx_ovr_o,
  output logic             rx_udf_o
);
  sfifo_core #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(IRQ_AT_OR_BELOW)) i_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tx_en_i),
    .flush_i   (tx_flush_i),
    .err_clr_i (tx_err_clr_i),
    .trig_i    (tx_trig_i),
    .len_i     (wlen_i),
    .push_i    (tx_wr_i),
    .wdata_i   (tx_wdata_i),
    .pop_i     (tx_pop_i),
    .rdata_o   (tx_rdata_o),
    .level_o   (tx_level_o),
    .irq_o     (tx_irq_o),
    .ovr_o     (tx_ovr_o),
    .udf_o     (tx_udf_o)
  );

  sfifo_core #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(IRQ_AT_OR_ABOVE)) i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rx_en_i),
    .flush_i   (rx_flush_i),
    .err_clr_i (rx_err_clr_i),
    .trig_i    (rx_trig_i),
    .len_i     (wlen_i),
    .push_i    (rx_push_i),
    .wdata_i   (rx_wdata_i),
    .pop_i     (rx_rd_i),
    .rdata_o   (rx_rdata_o),
    .level_o   (rx_level_o),
    .irq_o     (rx_irq_o),
    .ovr_o     (rx_ovr_o),
    .udf_o     (rx_udf_o)
  );
endmodule

// File: tb/test_sfifo_pair.sv
module test_sfifo_pair;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  wlen = 5'd16;
  logic        tx_en = 0, tx_flush = 0, tx_err_clr = 0, tx_wr = 0, tx_pop = 0;
  logic [3:0]  tx_trig = 4'd2;
  logic [15:0] tx_wdata = '0;
  logic [15:0] tx_rdata;
  logic [3:0]  tx_level;
  logic        tx_irq, tx_ovr, tx_udf;
  logic        rx_en = 0, rx_flush = 0, rx_err_clr = 0, rx_push = 0, rx_rd = 0;
  logic [3:0]  rx_trig = 4'd3;
  logic [15:0] rx_wdata = '0;
  logic [15:0] rx_rdata;
  logic [3:0]  rx_level;
  logic        rx_irq, rx_ovr, rx_udf;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfifo_pair i_sfifo_pair (
    .clk_i(clk), .rst_ni(rst_ni), .wlen_i(wlen),
    .tx_en_i(tx_en), .tx_flush_i(tx_flush), .tx_trig_i(tx_trig),
    .tx_err_clr_i(tx_err_clr), .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata),
    .tx_pop_i(tx_pop), .tx_rdata_o(tx_rdata), .tx_level_o(tx_level),
    .tx_irq_o(tx_irq), .tx_ovr_o(tx_ovr), .tx_udf_o(tx_udf),
    .rx_en_i(rx_en), .rx_flush_i(rx_flush), .rx_trig_i(rx_trig),
    .rx_err_clr_i(rx_err_clr), .rx_push_i(rx_push), .rx_wdata_i(rx_wdata),
    .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata), .rx_level_o(rx_level),
    .rx_irq_o(rx_irq), .rx_ovr_o(rx_ovr), .rx_udf_o(rx_udf)
  );

  typedef struct packed {
    logic        push;
    logic        rd;
    logic [15:0] data;
    logic [3:0]  lvl;
    logic        irq;
    logic [15:0] rdata;
  } vec_t;

  // rx trigger 3, word length 16
  localparam vec_t VEC [7] = '{
    '{1'b1, 1'b0, 16'hA001, 4'd1, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 16'hA002, 4'd2, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 16'hA003, 4'd3, 1'b1, 16'h0000},
    '{1'b0, 1'b1, 16'h0000, 4'd2, 1'b0, 16'hA001},
    '{1'b1, 1'b1, 16'hA004, 4'd2, 1'b0, 16'hA002},
    '{1'b0, 1'b1, 16'h0000, 4'd1, 1'b0, 16'hA003},
    '{1'b0, 1'b1, 16'h0000, 4'd0, 1'b0, 16'hA004}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    tx_wr = 0; tx_pop = 0; tx_flush = 0; tx_err_clr = 0;
    rx_push = 0; rx_rd = 0; rx_flush = 0; rx_err_clr = 0;
  endtask

  task automatic rx_op(input logic push, input logic rd, input logic [15:0] d);
    rx_push = push; rx_rd = rd; rx_wdata = d;
    tick();
  endtask

  task automatic tx_op(input logic wr, input logic pop, input logic [15:0] d);
    tx_wr = wr; tx_pop = pop; tx_wdata = d;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_level", 32'(rx_level), 0);
    chk("R1 tx_level", 32'(tx_level), 0);
    chk("R1 rdata", {tx_rdata, rx_rdata}, 0);
    chk("R1 flags", {28'd0, tx_ovr, tx_udf, rx_ovr, rx_udf}, 0);
    chk("R1 irqs", {30'd0, tx_irq, rx_irq}, 0);

    rx_en = 1; tx_en = 1;
    @(negedge clk);
    // R2/R4 table walk
    foreach (VEC[i]) begin
      rx_op(VEC[i].push, VEC[i].rd, VEC[i].data);
      chk("R2 table level", 32'(rx_level), 32'(VEC[i].lvl));
      chk("R4 table irq", 32'(rx_irq), 32'(VEC[i].irq));
      if (VEC[i].rd) chk("R2 table rdata", 32'(rx_rdata), 32'(VEC[i].rdata));
    end

    // R5 transmit irq at or below trigger 2
    chk("R5 tx irq empty", 32'(tx_irq), 1);
    for (int k = 0; k < 3; k++) tx_op(1, 0, 16'h5000 + 16'(k));
    chk("R5 tx level 3", 32'(tx_level), 3);
    chk("R5 tx irq above", 32'(tx_irq), 0);
    tx_op(0, 1, 0);
    chk("R2 tx order", 32'(tx_rdata), 32'h5000);
    chk("R5 tx irq at trig", 32'(tx_irq), 1);

    // R10 disabled queue
    tx_en = 0;
    tx_op(1, 0, 16'h7777);
    chk("R10 push ignored", 32'(tx_level), 2);
    chk("R10 irq low", 32'(tx_irq), 0);
    tx_op(0, 1, 0);
    chk("R10 pop ignored", 32'(tx_level), 2);
    chk("R10 data held", 32'(tx_rdata), 32'h5000);
    tx_en = 1;

    // R9 independent flush
    rx_op(1, 0, 16'h0011);
    rx_op(1, 0, 16'h0022);
    rx_flush = 1; tick();
    chk("R9 rx flushed", 32'(rx_level), 0);
    chk("R9 tx untouched", 32'(tx_level), 2);
    tx_op(0, 1, 0);
    chk("R9 tx data intact", 32'(tx_rdata), 32'h5001);
    tx_flush = 1; tick();
    chk("R9 tx flushed", 32'(tx_level), 0);

    // R6 overrun
    for (int k = 0; k < 9; k++) rx_op(1, 0, 16'd100 + 16'(k));
    chk("R6 level full", 32'(rx_level), 8);
    chk("R6 ovr set", 32'(rx_ovr), 1);
    for (int k = 0; k < 8; k++) begin
      rx_op(0, 1, 0);
      chk("R2 order after wrap", 32'(rx_rdata), 32'd100 + 32'(k));
    end
    chk("R6 ovr sticky", 32'(rx_ovr), 1);

    // R7 underflow
    rx_op(0, 1, 0);
    chk("R7 udf set", 32'(rx_udf), 1);
    chk("R7 data held", 32'(rx_rdata), 32'd107);
    chk("R7 level zero", 32'(rx_level), 0);
    chk("R7 tx flags clean", {30'd0, tx_ovr, tx_udf}, 0);

    // R8 clear
    rx_err_clr = 1; tick();
    chk("R8 cleared", {30'd0, rx_ovr, rx_udf}, 0);

    // R11 full exchange
    for (int k = 0; k < 8; k++) rx_op(1, 0, 16'h0200 + 16'(k));
    rx_op(1, 1, 16'h0299);
    chk("R11 level", 32'(rx_level), 8);
    chk("R11 no ovr", 32'(rx_ovr), 0);
    chk("R11 rdata", 32'(rx_rdata), 32'h0200);
    rx_flush = 1; tick();

    // R3 word length
    wlen = 5'd5;
    rx_op(1, 0, 16'hFFFF);
    rx_op(0, 1, 0);
    chk("R3 len 5", 32'(rx_rdata), 32'h001F);
    wlen = 5'd1;
    rx_op(1, 0, 16'hFFFF);
    rx_op(0, 1, 0);
    chk("R3 len clamp low", 32'(rx_rdata), 32'h0003);
    wlen = 5'd31;
    rx_op(1, 0, 16'hBEEF);
    rx_op(0, 1, 0);
    chk("R3 len clamp high", 32'(rx_rdata), 32'hBEEF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule